// File: doc/BRIEF.md
# Ethernet Audio Packet Filter

This block sits between a raw Ethernet receiver and an audio sink. Frames arrive as 32-bit words, one word in each clock cycle where `in_valid` is high. Each frame closes with a single-cycle end pulse: `frame_good` if the frame arrived intact, `frame_bad` if it was damaged. The block checks the header of every frame against a fixed broadcast destination, a fixed sender address and a fixed type code. It removes the header and passes only the PCM audio words of matching frames to the sink.

A word-position counter and a sticky match flag carry the decision. Each header word is compared on the clock where it arrives, so the header is never stored. Frames that fail the check, that stop early or that run past their nominal length send no further audio. Their remaining words are dropped until the end pulse. A single-cycle `aud_drop` pulse then tells the downstream buffer to discard the audio of any frame that did not finish cleanly.

Top module: `eth_audio_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `aud_valid`, `aud_drop` and `aud_word` to zero on that edge. It also clears the word position and sets the match flag, so the next word received counts as header word 0.
- R2: A frame is accepted only if all three header fields match. Word 0 must equal 0xFFFFFFFF, word 1 must equal 0xFFFF0090 and word 2 must equal 0xC2001C50. Bits 31:16 of word 3 must equal 0x0101. This covers the destination FFFF_FFFF_FFFF, the source 0090_C200_1C50 and the type 0x0101.
- R3: For an accepted frame, frame words 4 to 1027 appear on `aud_word` in arrival order. Each one has `aud_valid` high on the clock after it was received. Header words never appear on the output.
- R4: If any header field mismatches, the frame produces no `aud_valid` at all.
- R5: Bits 15:0 of word 3 (the padding) have no effect on acceptance.
- R6: A word counts only in a cycle where `in_valid` is high. In cycles where `in_valid` is low, `aud_valid` is low on the following clock.
- R7: Either end pulse returns the position to zero and resets the match flag, so the next frame is judged on its own header.
- R8: An end pulse raises `aud_drop` for exactly one cycle, on the clock after the pulse, if the pulse is `frame_bad`.
- R9: A frame that ends after fewer than 1028 words raises `aud_drop` for one cycle, even if it ends with `frame_good`. Its audio words before the end are still forwarded.
- R10: In a frame longer than 1028 words, no word after the 1028th is forwarded, and the frame's end pulse raises `aud_drop`.
- R11: An accepted frame of exactly 1028 words that ends with `frame_good` does not raise `aud_drop`.
- R12: A reset in the middle of a frame discards the partial frame. A complete frame sent after the reset is accepted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 32 | Received frame word |
| in_valid | input | 1 | `in_word` holds a word this cycle |
| frame_good | input | 1 | One-cycle pulse: the frame ended intact |
| frame_bad | input | 1 | One-cycle pulse: the frame ended corrupted |
| aud_word | output | 32 | Audio sample word |
| aud_valid | output | 1 | `aud_word` is valid this cycle |
| aud_drop | output | 1 | One-cycle pulse: discard the audio of the frame that just ended |

## Verification
The assertions assume the following about the inputs. An end pulse never arrives in the same cycle as a data word. The two end pulses are never high together. Two end pulses are always separated by at least one other cycle. The stimulus satisfies all three: it always leaves `in_valid` low in the cycle that carries an end pulse, drives only one end signal at a time, and clears it on the next cycle. Frames are also sent with idle gaps between words, so the word count cannot just follow the clock.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

    localparam int WORD_W      = 32;
    localparam int HDR_WORDS   = 4;
    localparam int PAY_WORDS   = 1024;
    localparam int FRAME_WORDS = HDR_WORDS + PAY_WORDS;
    localparam int CNT_W       = $clog2(FRAME_WORDS + 1);

    localparam logic [47:0] DST_ADDR = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] SRC_ADDR = 48'h0090_C200_1C50;
    localparam logic [15:0] ETH_TYPE = 16'h0101;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  pos_t;

    // Expected value of one header word, and which of its bits are compared
    typedef struct packed {
        word_t value;
        word_t care;
    } hdr_ref_t;

    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_GOOD = 2'd1,
        END_BAD  = 2'd2
    } end_kind_t;

    function automatic hdr_ref_t hdr_ref(input logic [1:0] idx);
        hdr_ref_t r;
        case (idx)
            2'd0:    r = '{value: DST_ADDR[47:16],                 care: '1};
            2'd1:    r = '{value: {DST_ADDR[15:0], SRC_ADDR[47:32]}, care: '1};
            2'd2:    r = '{value: SRC_ADDR[31:0],                  care: '1};
            default: r = '{value: {ETH_TYPE, 16'h0000},            care: {16'hFFFF, 16'h0000}};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eaf_pos_counter.sv
module eaf_pos_counter #(
    parameter int CNT_W = eaf_pkg::CNT_W,
    parameter int LIMIT = eaf_pkg::FRAME_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_en,
    input  logic             frame_end,
    output logic [CNT_W-1:0] pos,
    output logic             at_limit
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    assign at_limit = (pos == LIM);

    // Saturates at the frame length: any word seen there belongs to an overlong frame
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            pos <= '0;
        end else if (word_en && !at_limit) begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/eaf_verdict.sv
module eaf_verdict #(
    parameter int WORD_W    = eaf_pkg::WORD_W,
    parameter int CNT_W     = eaf_pkg::CNT_W,
    parameter int HDR_WORDS = eaf_pkg::HDR_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_en,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  pos,
    input  logic              at_limit,
    input  logic [WORD_W-1:0] word,
    output logic              ok
);
    import eaf_pkg::*;

    logic     in_hdr;
    logic     hdr_hit;
    hdr_ref_t ref_w;

    assign in_hdr = (pos < CNT_W'(HDR_WORDS));

    always_comb begin
        ref_w   = hdr_ref(pos[1:0]);
        hdr_hit = (((word ^ ref_w.value) & ref_w.care) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            ok <= 1'b1;
        end else if (word_en) begin
            if ((in_hdr && !hdr_hit) || at_limit) begin
                ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/eaf_out_stage.sv
module eaf_out_stage #(
    parameter int WORD_W = eaf_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic              drop_en,
    output logic [WORD_W-1:0] aud_word,
    output logic              aud_valid,
    output logic              aud_drop
);
    always_ff @(posedge clk) begin
        if (rst) begin
            aud_word  <= '0;
            aud_valid <= 1'b0;
            aud_drop  <= 1'b0;
        end else begin
            aud_valid <= fwd_en;
            aud_drop  <= drop_en;
            if (fwd_en) begin
                aud_word <= word_in;
            end
        end
    end
endmodule

// File: rtl/eth_audio_filter.sv
module eth_audio_filter (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] in_word,
    input  logic        in_valid,
    input  logic        frame_good,
    input  logic        frame_bad,
    output logic [31:0] aud_word,
    output logic        aud_valid,
    output logic        aud_drop
);
    import eaf_pkg::*;

    end_kind_t end_kind;
    logic      frame_end;
    logic      word_en;
    pos_t      pos_q;
    logic      at_limit;
    logic      ok_q;
    logic      in_payload;
    logic      fwd_en;
    logic      clean_end;
    logic      drop_en;

    always_comb begin
        if (frame_bad)       end_kind = END_BAD;
        else if (frame_good) end_kind = END_GOOD;
        else                 end_kind = END_NONE;
    end

    assign frame_end  = (end_kind != END_NONE);
    assign word_en    = in_valid && !frame_end;
    assign in_payload = (pos_q >= CNT_W'(HDR_WORDS)) && !at_limit;
    assign fwd_en     = word_en && ok_q && in_payload;
    assign clean_end  = (end_kind == END_GOOD) && ok_q && at_limit;
    assign drop_en    = frame_end && !clean_end;

    eaf_pos_counter #(.CNT_W(CNT_W), .LIMIT(FRAME_WORDS)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .word_en  (word_en),
        .frame_end(frame_end),
        .pos      (pos_q),
        .at_limit (at_limit)
    );

    eaf_verdict #(.WORD_W(WORD_W), .CNT_W(CNT_W), .HDR_WORDS(HDR_WORDS)) u_verdict (
        .clk      (clk),
        .rst      (rst),
        .word_en  (word_en),
        .frame_end(frame_end),
        .pos      (pos_q),
        .at_limit (at_limit),
        .word     (in_word),
        .ok       (ok_q)
    );

    eaf_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .fwd_en   (fwd_en),
        .word_in  (in_word),
        .drop_en  (drop_en),
        .aud_word (aud_word),
        .aud_valid(aud_valid),
        .aud_drop (aud_drop)
    );
endmodule

module eaf_checker #(
    parameter int CNT_W       = eaf_pkg::CNT_W,
    parameter int HDR_WORDS   = eaf_pkg::HDR_WORDS,
    parameter int FRAME_WORDS = eaf_pkg::FRAME_WORDS
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             frame_good,
    input logic             frame_bad,
    input logic             aud_valid,
    input logic             aud_drop,
    input logic [CNT_W-1:0] pos,
    input logic             ok
);
    // R3
    fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
        aud_valid |-> $past(in_valid));

    // R3
    hdr_strip_chk: assert property (@(posedge clk) disable iff (rst)
        aud_valid |-> ($past(pos) >= CNT_W'(HDR_WORDS)));

    // R4
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        !ok |=> !aud_valid);

    // R7
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_good || frame_bad) |=> (pos == '0 && ok));

    // R8
    drop_src_chk: assert property (@(posedge clk) disable iff (rst)
        aud_drop |-> $past(frame_good || frame_bad));

    // R10
    long_sup_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pos == CNT_W'(FRAME_WORDS)) |=> !aud_valid);

    // R11
    good_nodrop_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_good && !frame_bad && ok && pos == CNT_W'(FRAME_WORDS)) |=> !aud_drop);
endmodule

bind eth_audio_filter eaf_checker #(
    .CNT_W      (eaf_pkg::CNT_W),
    .HDR_WORDS  (eaf_pkg::HDR_WORDS),
    .FRAME_WORDS(eaf_pkg::FRAME_WORDS)
) u_eaf_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .frame_good(frame_good),
    .frame_bad (frame_bad),
    .aud_valid (aud_valid),
    .aud_drop  (aud_drop),
    .pos       (pos_q),
    .ok        (ok_q)
);

// File: tb/test_eth_audio_filter.sv
`timescale 1ns/1ps
module test_eth_audio_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        frame_good = 1'b0;
    logic        frame_bad = 1'b0;
    logic [31:0] aud_word;
    logic        aud_valid;
    logic        aud_drop;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] H0 = 32'hFFFF_FFFF;
    localparam logic [31:0] H1 = 32'hFFFF_0090;
    localparam logic [31:0] H2 = 32'hC200_1C50;
    localparam logic [31:0] H3 = 32'h0101_0000;

    always #2 clk = ~clk;

    eth_audio_filter i_eth_audio_filter (
        .clk       (clk),
        .rst       (rst),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .frame_good(frame_good),
        .frame_bad (frame_bad),
        .aud_word  (aud_word),
        .aud_valid (aud_valid),
        .aud_drop  (aud_drop)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_total++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // end_kind: 0 none, 1 intact, 2 corrupted
    task automatic send_frame(input logic [31:0] h0, h1, h2, h3, input int n,
                              input int end_kind, input int gap_every, input logic [7:0] tag,
                              output int fwd, output int mism, output int hdr_leak,
                              output int gap_leak, output int drop_pulses, output bit drop_one);
        logic [31:0] hw [4];
        hw = '{h0, h1, h2, h3};
        fwd = 0; mism = 0; hdr_leak = 0; gap_leak = 0; drop_pulses = 0; drop_one = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = (i < 4) ? hw[i] : {tag, 24'(i)};
            @(posedge clk); #1;
            if (aud_drop) drop_pulses++;
            if (aud_valid) begin
                fwd++;
                if (i < 4) hdr_leak++;
                else if (aud_word != {tag, 24'(i)}) mism++;
            end
            if (gap_every > 0 && (i % gap_every) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk); #1;
                if (aud_valid) gap_leak++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (end_kind != 0) begin
            frame_good = (end_kind == 1);
            frame_bad  = (end_kind == 2);
            @(posedge clk); #1;
            if (aud_valid) gap_leak++;
            @(negedge clk);
            frame_good = 1'b0;
            frame_bad  = 1'b0;
            if (aud_drop) drop_pulses++;
            @(posedge clk); #1;
            if (aud_drop) drop_one = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(aud_valid == 1'b0, "R1", "aud_valid after reset", aud_valid, 0);
        check(aud_drop == 1'b0, "R1", "aud_drop after reset", aud_drop, 0);
        check(aud_word == 32'h0, "R1", "aud_word after reset", aud_word, 0);
    endtask

    task automatic t_good_frame();
        int f, m, hl, gl, dp; bit d1;
        send_frame(H0, H1, H2, H3, 1028, 1, 0, 8'hA1, f, m, hl, gl, dp, d1);
        check(f == 1024, "R3", "good frame forwarded count", f, 1024);
        check(m == 0, "R3", "good frame payload mismatches", m, 0);
        check(hl == 0, "R3", "header words on output", hl, 0);
        check(dp == 0, "R11", "drop pulses on clean frame", dp, 0);
    endtask

    task automatic t_bad_headers();
        int f, m, hl, gl, dp; bit d1;
        send_frame(32'hFFFF_FFFE, H1, H2, H3, 1028, 1, 0, 8'hB1, f, m, hl, gl, dp, d1);
        check(f == 0, "R4", "wrong destination forwarded", f, 0);
        send_frame(H0, 32'hFFFF_0091, H2, H3, 1028, 1, 0, 8'hB2, f, m, hl, gl, dp, d1);
        check(f == 0, "R4", "wrong source upper forwarded", f, 0);
        send_frame(H0, H1, 32'hC200_1C51, H3, 1028, 1, 0, 8'hB3, f, m, hl, gl, dp, d1);
        check(f == 0, "R4", "wrong source lower forwarded", f, 0);
        send_frame(H0, H1, H2, 32'h0800_0000, 1028, 1, 0, 8'hB4, f, m, hl, gl, dp, d1);
        check(f == 0, "R2", "wrong type forwarded", f, 0);
    endtask

    task automatic t_padding();
        int f, m, hl, gl, dp; bit d1;
        send_frame(H0, H1, H2, 32'h0101_BEEF, 1028, 1, 0, 8'hC1, f, m, hl, gl, dp, d1);
        check(f == 1024 && m == 0, "R5", "padding changed acceptance", f, 1024);
        check(dp == 0, "R5", "padding frame drop pulses", dp, 0);
    endtask

    task automatic t_gaps();
        int f, m, hl, gl, dp; bit d1;
        send_frame(H0, H1, H2, H3, 1028, 1, 3, 8'hD1, f, m, hl, gl, dp, d1);
        check(gl == 0, "R6", "aud_valid during idle cycles", gl, 0);
        check(f == 1024 && m == 0, "R6", "gapped frame forwarded count", f, 1024);
        check(dp == 0, "R6", "gapped frame drop pulses", dp, 0);
    endtask

    task automatic t_boundaries();
        int f, m, hl, gl, dp; bit d1;
        // rejected frame, then a good frame must be judged afresh
        send_frame(H0, H1, H2, 32'h0202_0000, 1028, 1, 0, 8'hE0, f, m, hl, gl, dp, d1);
        send_frame(H0, H1, H2, H3, 1028, 1, 0, 8'hE1, f, m, hl, gl, dp, d1);
        check(f == 1024 && m == 0, "R7", "frame after rejected frame", f, 1024);
        // corrupted end on full frame
        send_frame(H0, H1, H2, H3, 1028, 2, 0, 8'hE2, f, m, hl, gl, dp, d1);
        check(dp == 1 && d1, "R8", "drop pulse on corrupted end", dp, 1);
        // short frame with intact end
        send_frame(H0, H1, H2, H3, 500, 1, 0, 8'hE3, f, m, hl, gl, dp, d1);
        check(f == 496 && m == 0, "R9", "short frame forwarded count", f, 496);
        check(dp == 1 && d1, "R9", "drop pulse on short frame", dp, 1);
        send_frame(H0, H1, H2, H3, 1028, 1, 0, 8'hE4, f, m, hl, gl, dp, d1);
        check(f == 1024 && dp == 0, "R7", "frame after short frame", f, 1024);
        // overlong frame
        send_frame(H0, H1, H2, H3, 1100, 1, 0, 8'hE5, f, m, hl, gl, dp, d1);
        check(f == 1024 && m == 0, "R10", "long frame forwarded count", f, 1024);
        check(dp == 1 && d1, "R10", "drop pulse on long frame", dp, 1);
        send_frame(H0, H1, H2, H3, 1028, 1, 0, 8'hE6, f, m, hl, gl, dp, d1);
        check(f == 1024 && dp == 0, "R7", "frame after long frame", f, 1024);
    endtask

    task automatic t_mid_reset();
        int f, m, hl, gl, dp; bit d1;
        send_frame(H0, H1, H2, H3, 300, 0, 0, 8'hF0, f, m, hl, gl, dp, d1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(aud_valid == 1'b0 && aud_drop == 1'b0, "R12", "outputs during mid-frame reset",
              {aud_valid, aud_drop}, 0);
        @(negedge clk);
        rst = 1'b0;
        send_frame(H0, H1, H2, H3, 1028, 1, 0, 8'hF1, f, m, hl, gl, dp, d1);
        check(f == 1024 && m == 0, "R12", "frame after mid-frame reset", f, 1024);
        check(dp == 0, "R12", "drop pulses after mid-frame reset", dp, 0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        rst = 1'b0;
        t_good_frame();
        t_bad_headers();
        t_padding();
        t_gaps();
        t_boundaries();
        t_mid_reset();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule